// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register made of eight 4-bit fields and the logic that writes and reads it. Each field carries four flags: less-than, greater-than, equal and summary overflow. A compare port evaluates two operands as signed or unsigned numbers and places the outcome in one chosen field. A bit-logic port combines any two register bits with a Boolean operation and stores the result in any third bit. This lets several compare results be merged into one flag without branching.

The register can also be loaded as a whole word, read out as a word, and updated by copying one field into another. A branch-condition output tests one flag of one field against a required polarity. A branch unit uses that output to decide whether a conditional jump is taken. At most one write lands per clock, and a fixed priority picks the winner when several ports request a write in the same cycle.

Top module: `crlu_top`

## Requirements
- R1: A synchronous active-high `rst` clears the whole register to 0, and `cr_word` shows 0 in the cycle after reset.
- R2: Field f occupies `cr_word[4f+3:4f]`, and the flag offsets inside a field are lt=0, gt=1, eq=2, so=3, so absolute bit index = 4*field + offset. A compare writes {so_in, eq, gt, lt} into field `cmp_field` only. Every other bit keeps its value, and the result is visible on `cr_word` one clock after `cmp_en`.
- R3: Each compare sets exactly one of lt, gt and eq. With `cmp_signed`=1 the operands are two's-complement; with 0 they are unsigned, so the same operands can give opposite lt/gt results.
- R4: When `lg_en` is set, `lg_op` selects the operation: 0 and, 1 or, 2 xor, 3 nor, 4 eqv (xnor), 5 andc (A and not B), 6 orc (A or not B). The result of bit `lg_src_a` op bit `lg_src_b` goes to bit `lg_dst`. Sources are read from the value held before the clock edge, even when a source is also the destination.
- R5: With both sources equal to the same bit b, eqv sets the destination, xor clears it, or copies b and nor writes the inverse of b.
- R6: `lg_op`=7 is reserved and writes nothing. The register is unchanged.
- R7: `mv_en` copies all four bits of field `mv_src` into field `mv_dst` and leaves every other field unchanged.
- R8: `ld_en` loads `ld_word` into the whole register. `cr_word` always presents the current register value.
- R9: Write priority is load, then field copy, then bit-logic, then compare. Only the highest-priority request is committed in a clock. When no port requests a write, the register holds its value.
- R10: `br_take` is combinational and equals 1 exactly when bit 4*`br_field`+`br_flag` of the register equals `br_want`. For example, not-equal is tested as eq with `br_want`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Compare write request |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_field | input | 3 | Destination field of the compare |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| so_in | input | 1 | Sticky overflow copied into the so flag |
| lg_en | input | 1 | Bit-logic write request |
| lg_op | input | 3 | Bit-logic operation code |
| lg_src_a | input | 5 | First source bit index |
| lg_src_b | input | 5 | Second source bit index |
| lg_dst | input | 5 | Destination bit index |
| mv_en | input | 1 | Field copy request |
| mv_src | input | 3 | Source field |
| mv_dst | input | 3 | Destination field |
| ld_en | input | 1 | Whole-word load request |
| ld_word | input | 32 | Word to load |
| cr_word | output | 32 | Current register value |
| br_field | input | 3 | Field tested by the branch condition |
| br_flag | input | 2 | Flag offset tested |
| br_want | input | 1 | Required polarity of the tested flag |
| br_take | output | 1 | Branch condition result |

## Verification
The assertions assume that every enable and every index is a known 0 or 1 whenever reset is low. They also assume that a compare, copy or load request lasts a single cycle, because each property compares the register one clock later with the inputs sampled at the request. The stimulus drives every control input to a defined value from time zero. It raises each enable for exactly one clock and returns it to 0 before the next check. Requests overlap only in the priority tests, and there the properties for the lower-priority ports are written so that they stay silent.

// File: rtl/crlu_pkg.sv
package crlu_pkg;

    localparam int FLAG_W   = 4;
    localparam int FLAG_IW  = $clog2(FLAG_W);

    typedef enum logic [1:0] {
        FL_LT = 2'd0,
        FL_GT = 2'd1,
        FL_EQ = 2'd2,
        FL_SO = 2'd3
    } flag_e;

    typedef enum logic [2:0] {
        BOP_AND  = 3'd0,
        BOP_OR   = 3'd1,
        BOP_XOR  = 3'd2,
        BOP_NOR  = 3'd3,
        BOP_EQV  = 3'd4,
        BOP_ANDC = 3'd5,
        BOP_ORC  = 3'd6,
        BOP_NONE = 3'd7
    } bop_e;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_LOAD,
        WR_MOVE,
        WR_BIT,
        WR_CMP
    } wsrc_e;

    // packed so that the struct lines up with bit offsets 3..0 of a field
    typedef struct packed {
        logic so;
        logic eq;
        logic gt;
        logic lt;
    } flags_t;

    function automatic logic bop_eval(bop_e op, logic a, logic b);
        logic r;
        case (op)
            BOP_AND:  r = a & b;
            BOP_OR:   r = a | b;
            BOP_XOR:  r = a ^ b;
            BOP_NOR:  r = ~(a | b);
            BOP_EQV:  r = ~(a ^ b);
            BOP_ANDC: r = a & ~b;
            BOP_ORC:  r = a | ~b;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    // fixed write priority: load > field copy > bit logic > compare
    function automatic wsrc_e pick_writer(logic ld, logic mv, logic bl, logic cm);
        wsrc_e w;
        if (ld)      w = WR_LOAD;
        else if (mv) w = WR_MOVE;
        else if (bl) w = WR_BIT;
        else if (cm) w = WR_CMP;
        else         w = WR_IDLE;
        return w;
    endfunction

endpackage

// File: rtl/crlu_cmp.sv
module crlu_cmp
    import crlu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              sgn,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              so_in,
    output flags_t            res
);
    logic a_lt_b;
    logic same;

    always_comb begin
        same = (op_a == op_b);
        if (sgn) a_lt_b = ($signed(op_a) < $signed(op_b));
        else     a_lt_b = (op_a < op_b);
        res.so = so_in;
        res.eq = same;
        res.lt = a_lt_b;
        res.gt = !same && !a_lt_b;
    end
endmodule

// File: rtl/crlu_bitop.sv
module crlu_bitop
    import crlu_pkg::*;
#(
    parameter int NBITS = 32,
    localparam int IW   = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] word,
    input  logic [2:0]       op,
    input  logic [IW-1:0]    idx_a,
    input  logic [IW-1:0]    idx_b,
    output logic             bit_res,
    output logic             active
);
    bop_e op_e;

    always_comb begin
        op_e    = bop_e'(op);
        bit_res = bop_eval(op_e, word[idx_a], word[idx_b]);
        active  = (op_e != BOP_NONE);
    end
endmodule

// File: rtl/crlu_cond.sv
module crlu_cond
    import crlu_pkg::*;
#(
    parameter int NFIELD = 8,
    localparam int FSW   = $clog2(NFIELD),
    localparam int NBITS = NFIELD * FLAG_W
) (
    input  logic [NBITS-1:0]   word,
    input  logic [FSW-1:0]     field,
    input  logic [FLAG_IW-1:0] flag,
    input  logic               want,
    output logic               take
);
    logic picked;

    always_comb begin
        picked = word[{field, flag}];
        take   = (picked == want);
    end
endmodule

// File: rtl/crlu_top.sv
module crlu_top
    import crlu_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int DATA_W = 32,
    localparam int WORD_W = NFIELD * FLAG_W,
    localparam int FSW    = $clog2(NFIELD),
    localparam int BIW    = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmp_en,
    input  logic                 cmp_signed,
    input  logic [FSW-1:0]       cmp_field,
    input  logic [DATA_W-1:0]    cmp_a,
    input  logic [DATA_W-1:0]    cmp_b,
    input  logic                 so_in,
    input  logic                 lg_en,
    input  logic [2:0]           lg_op,
    input  logic [BIW-1:0]       lg_src_a,
    input  logic [BIW-1:0]       lg_src_b,
    input  logic [BIW-1:0]       lg_dst,
    input  logic                 mv_en,
    input  logic [FSW-1:0]       mv_src,
    input  logic [FSW-1:0]       mv_dst,
    input  logic                 ld_en,
    input  logic [WORD_W-1:0]    ld_word,
    output logic [WORD_W-1:0]    cr_word,
    input  logic [FSW-1:0]       br_field,
    input  logic [FLAG_IW-1:0]   br_flag,
    input  logic                 br_want,
    output logic                 br_take
);
    logic [WORD_W-1:0] cr_q;
    logic [WORD_W-1:0] cr_d;
    flags_t            cmp_res;
    logic              bit_res;
    logic              bit_act;
    wsrc_e             writer;

    crlu_cmp #(.DATA_W(DATA_W)) u_cmp (
        .sgn   (cmp_signed),
        .op_a  (cmp_a),
        .op_b  (cmp_b),
        .so_in (so_in),
        .res   (cmp_res)
    );

    crlu_bitop #(.NBITS(WORD_W)) u_bitop (
        .word    (cr_q),
        .op      (lg_op),
        .idx_a   (lg_src_a),
        .idx_b   (lg_src_b),
        .bit_res (bit_res),
        .active  (bit_act)
    );

    crlu_cond #(.NFIELD(NFIELD)) u_cond (
        .word  (cr_q),
        .field (br_field),
        .flag  (br_flag),
        .want  (br_want),
        .take  (br_take)
    );

    always_comb begin
        writer = pick_writer(ld_en, mv_en, lg_en && bit_act, cmp_en);
        cr_d   = cr_q;
        case (writer)
            WR_LOAD: cr_d = ld_word;
            WR_MOVE: cr_d[mv_dst*FLAG_W +: FLAG_W] = cr_q[mv_src*FLAG_W +: FLAG_W];
            WR_BIT:  cr_d[lg_dst] = bit_res;
            WR_CMP:  cr_d[cmp_field*FLAG_W +: FLAG_W] = cmp_res;
            default: cr_d = cr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cr_q <= '0;
        else     cr_q <= cr_d;
    end

    assign cr_word = cr_q;

    // R3: compare unit always reports exactly one ordering flag
    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        cmp_en |-> $countones({cmp_res.lt, cmp_res.gt, cmp_res.eq}) == 1);

    // R8: a load overrides everything else
    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> cr_q == $past(ld_word));

    // R7: field copy lands in the destination field
    assert_move_R7: assert property (@(posedge clk) disable iff (rst)
        (mv_en && !ld_en) |=>
        cr_q[$past(mv_dst)*FLAG_W +: FLAG_W] == $past(cr_q[mv_src*FLAG_W +: FLAG_W]));

    // R2: a lone compare carries the sticky overflow into its field
    assert_cmp_so_R2: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !ld_en && !mv_en && !lg_en) |=>
        cr_q[$past(cmp_field)*FLAG_W + 3] == $past(so_in));

    // R9: no request, no change
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !mv_en && !lg_en && !cmp_en) |=> $stable(cr_q));

endmodule

// File: tb/test_crlu_top.sv
module test_crlu_top;
    import crlu_pkg::*;

    typedef struct packed {
        logic        sg;
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  f;
        logic        so;
        logic [3:0]  nib;
    } vec_t;

    // expected nibble = {so, eq, gt, lt}
    localparam vec_t VECS [8] = '{
        '{1'b1, 32'd5,        32'd5,        3'd0, 1'b0, 4'b0100},
        '{1'b1, 32'hFFFFFFFF, 32'd1,        3'd1, 1'b0, 4'b0001},
        '{1'b0, 32'hFFFFFFFF, 32'd1,        3'd2, 1'b1, 4'b1010},
        '{1'b1, 32'h80000000, 32'h7FFFFFFF, 3'd3, 1'b0, 4'b0001},
        '{1'b0, 32'h80000000, 32'h7FFFFFFF, 3'd4, 1'b0, 4'b0010},
        '{1'b0, 32'd3,        32'd9,        3'd5, 1'b1, 4'b1001},
        '{1'b1, 32'd9,        32'd3,        3'd6, 1'b0, 4'b0010},
        '{1'b0, 32'd0,        32'd0,        3'd7, 1'b1, 4'b1100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_en = 0, cmp_signed = 0, so_in = 0;
    logic [2:0]  cmp_field = 0;
    logic [31:0] cmp_a = 0, cmp_b = 0;
    logic        lg_en = 0;
    logic [2:0]  lg_op = 0;
    logic [4:0]  lg_src_a = 0, lg_src_b = 0, lg_dst = 0;
    logic        mv_en = 0;
    logic [2:0]  mv_src = 0, mv_dst = 0;
    logic        ld_en = 0;
    logic [31:0] ld_word = 0;
    logic [31:0] cr_word;
    logic [2:0]  br_field = 0;
    logic [1:0]  br_flag = 0;
    logic        br_want = 0;
    logic        br_take;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = 0;

    always #2 clk = ~clk;

    crlu_top i_crlu_top (
        .clk(clk), .rst(rst),
        .cmp_en(cmp_en), .cmp_signed(cmp_signed), .cmp_field(cmp_field),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .so_in(so_in),
        .lg_en(lg_en), .lg_op(lg_op), .lg_src_a(lg_src_a),
        .lg_src_b(lg_src_b), .lg_dst(lg_dst),
        .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
        .ld_en(ld_en), .ld_word(ld_word), .cr_word(cr_word),
        .br_field(br_field), .br_flag(br_flag), .br_want(br_want),
        .br_take(br_take)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drop_all;
        cmp_en = 0; lg_en = 0; mv_en = 0; ld_en = 0;
    endtask

    function automatic logic ref_op(int op, logic a, logic b);
        case (op)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            3: return ~(a | b);
            4: return ~(a ^ b);
            5: return a & ~b;
            6: return a | ~b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_logic(int op, int sa, int sb, int d);
        lg_en = 1; lg_op = 3'(op);
        lg_src_a = 5'(sa); lg_src_b = 5'(sb); lg_dst = 5'(d);
        tick;
        lg_en = 0;
        if (op != 7) model[d] = ref_op(op, model[sa], model[sb]);
    endtask

    task automatic do_load(logic [31:0] w);
        ld_en = 1; ld_word = w;
        tick;
        ld_en = 0;
        model = w;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // reset state
        tick; tick;
        rst = 0;
        check("R1 reset value", cr_word, 32'h0);

        // compare vectors from the table
        for (int i = 0; i < 8; i++) begin
            cmp_en = 1; cmp_signed = VECS[i].sg;
            cmp_a = VECS[i].a; cmp_b = VECS[i].b;
            cmp_field = VECS[i].f; so_in = VECS[i].so;
            tick;
            cmp_en = 0;
            model[VECS[i].f*4 +: 4] = VECS[i].nib;
            check("R2 R3 compare into field", cr_word, model);
        end

        // word load
        do_load(32'hA5C30F96);
        check("R8 word load", cr_word, 32'hA5C30F96);

        // all bit-logic ops over the four input combinations
        // bits 0..3 hold 0,1,1,0; pairs (0,3)=00 (0,1)=01 (1,0)=10 (1,2)=11
        for (int op = 0; op < 7; op++) begin
            for (int p = 0; p < 4; p++) begin
                int sa, sb;
                sa = (p < 2) ? 0 : 1;
                sb = (p == 0) ? 3 : (p == 1) ? 1 : (p == 2) ? 0 : 2;
                do_logic(op, sa, sb, 16 + ((op * 4 + p) % 16));
                check("R4 bit logic op", cr_word, model);
            end
        end

        // self-source idioms
        do_logic(4, 9, 9, 9);
        check("R5 set via eqv", cr_word, model);
        check("R5 bit 9 high", 32'(cr_word[9]), 32'h1);
        do_logic(2, 9, 9, 9);
        check("R5 clear via xor", 32'(cr_word[9]), 32'h0);
        do_logic(1, 4, 4, 12);
        check("R5 copy via or", cr_word, model);
        do_logic(3, 4, 4, 13);
        check("R5 invert via nor", cr_word, model);

        // destination is also a source: old value used
        do_logic(5, 7, 6, 7);
        check("R4 destination reads old value", cr_word, model);

        // reserved op writes nothing
        do_logic(7, 0, 1, 2);
        check("R6 reserved op no write", cr_word, model);

        // field copy
        mv_en = 1; mv_src = 3'd2; mv_dst = 3'd6;
        tick;
        mv_en = 0;
        model[24 +: 4] = model[8 +: 4];
        check("R7 field copy", cr_word, model);

        // priority: all four at once, load wins
        ld_en = 1; ld_word = 32'h12345678;
        mv_en = 1; mv_src = 3'd0; mv_dst = 3'd7;
        lg_en = 1; lg_op = 3'd4; lg_src_a = 5'd1; lg_src_b = 5'd1; lg_dst = 5'd1;
        cmp_en = 1; cmp_field = 3'd3; cmp_signed = 0; cmp_a = 0; cmp_b = 0; so_in = 1;
        tick;
        drop_all;
        model = 32'h12345678;
        check("R9 load beats all", cr_word, model);

        // copy beats bit logic and compare
        mv_en = 1; lg_en = 1; cmp_en = 1;
        tick;
        drop_all;
        model[28 +: 4] = model[0 +: 4];
        check("R9 copy beats logic and compare", cr_word, model);

        // bit logic beats compare
        lg_en = 1; lg_op = 3'd4; lg_src_a = 5'd0; lg_src_b = 5'd0; lg_dst = 5'd0;
        cmp_en = 1; cmp_field = 3'd0;
        tick;
        drop_all;
        model[0] = 1'b1;
        check("R9 logic beats compare", cr_word, model);

        // idle cycles hold
        tick; tick;
        check("R9 idle hold", cr_word, model);

        // branch condition over every bit, both polarities
        for (int b = 0; b < 32; b++) begin
            for (int w = 0; w < 2; w++) begin
                br_field = 3'(b / 4); br_flag = 2'(b % 4); br_want = w[0];
                #1;
                check("R10 branch condition", 32'(br_take), 32'(model[b] == w[0]));
            end
        end

        // reset in mid-run
        rst = 1;
        tick;
        rst = 0;
        check("R1 reset after activity", cr_word, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule